// File: doc/BRIEF.md
# Handshaked Port Bridge

This block connects one internal rendezvous channel to a set of external pins. The channel has no buffering and serves one internal partner at a time. Each instance works in a single direction, chosen at build time. An input instance takes a word from the environment and gives it to an internal reader. An output instance takes a word from an internal writer and gives it to the environment.

Two ready lines carry the handshake across the pins. The sender-ready line belongs to the side that has data to send, and the receiver-ready line belongs to the side that wants to take data. A word moves on a clock edge where both lines are high. The block changes its own pins only on rising clock edges and samples the environment's pins only on rising clock edges.

The internal side raises a request and then holds it. A one-cycle done pulse follows the edge on which the transfer commits. A build parameter may remove either ready line. An output port with no receiver-ready line accepts every send at once, and its sender-ready line then acts as a one-cycle data-valid strobe. An output port with neither line drives its data register on the pins at all times, with no valid indication.

Top module: `hsport_bridge`

## Requirements
- R1: While reset is held, and right after it is released, int_done, ext_wr_rdy_out, ext_rd_rdy_out, ext_data_out and int_rdata are all 0.
- R2: The block's own ready line goes high on the first clock edge where int_req is sampled high and no done pulse is showing. On an input port this line is ext_rd_rdy_out; on an output port it is ext_wr_rdy_out. The line stays high until the transfer commits.
- R3: A transfer commits on a rising edge where both ready lines are high. On that same edge the block's own ready line falls. int_done is high for exactly the one cycle that follows.
- R4: On an input port, int_rdata takes the value of ext_data_in sampled on the commit edge. That value is valid while int_done is high.
- R5: On an output port, ext_data_out loads int_wdata on the edge where the block's ready line rises. It then holds that value until int_done, even if int_wdata changes. Bit 0 is the least significant bit.
- R6: If the environment leaves its ready line high after a transfer, that level counts as a request for the next transfer. No transfer happens while int_req is low. The next internal request commits on the first edge where the block's ready line is already high.
- R7: While the environment's ready line is low, nothing commits. The block's ready line stays high for as long as this lasts.
- R8: An output port built without the receiver-ready line commits on the edge after its sender-ready line rises. ext_wr_rdy_out is therefore a one-cycle data-valid strobe.
- R9: An output port built with neither handshake line keeps ext_wr_rdy_out at 0. It drives its data register on ext_data_out at all times. Its done pulse has the same timing as in R8.
- R10: Pins that belong to the other direction are held at 0. An input port drives ext_data_out and ext_wr_rdy_out at 0. An output port drives ext_rd_rdy_out and int_rdata at 0.
- R11: An input port built without the sender-ready line treats the environment as always ready. It commits on the edge after ext_rd_rdy_out rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity happens on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| int_req | input | 1 | Internal partner is ready to transfer; held until int_done |
| int_wdata | input | DATA_W | Word from the internal writer (output port) |
| int_rdata | output | DATA_W | Word captured for the internal reader (input port) |
| int_done | output | 1 | One-cycle pulse after the commit edge |
| ext_data_in | input | DATA_W | Data pins driven by the environment (input port) |
| ext_data_out | output | DATA_W | Data pins driven by the block (output port) |
| ext_wr_rdy_in | input | 1 | Sender-ready line from the environment (input port) |
| ext_wr_rdy_out | output | 1 | Sender-ready line from the block (output port) |
| ext_rd_rdy_in | input | 1 | Receiver-ready line from the environment (output port) |
| ext_rd_rdy_out | output | 1 | Receiver-ready line from the block (input port) |

## Verification
Two assumptions about the inputs underlie the assertions. The first is that int_req stays high from the moment it is raised until int_done is seen. The second is that the environment never withdraws a ready level before a transfer commits, because what happens then is left undefined. The bench keeps to both assumptions. Its driver drops int_req and the environment's ready line only on the cycle where done is showing, or holds that line high on purpose to test R6. It raises lines only between edges. Every delay it applies on the environment's side is a delay in raising a line, never in lowering one.

// File: rtl/hsport_pkg.sv
// Shared types for the handshaked port bridge.
package hsport_pkg;
    // Direction of one bridge instance, seen from the internal side.
    typedef enum logic {
        PORT_IN  = 1'b0,
        PORT_OUT = 1'b1
    } port_dir_e;
endpackage

// File: rtl/hsport_sync.sv
// Handshake scheduler: owns the block's ready register and the done pulse.
// Assumes the internal request is held until done and that the remote ready
// level is never withdrawn before the transfer commits.
module hsport_sync #(
    parameter bit HAS_REMOTE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic remote_rdy_i,
    output logic local_rdy_o,
    output logic commit_o,
    output logic done_o
);
    logic remote_eff;
    logic loc_q;
    logic done_q;
    logic unused_sync;

    // An omitted remote line is treated as permanently ready.
    assign remote_eff  = HAS_REMOTE ? remote_rdy_i : 1'b1;
    assign unused_sync = remote_rdy_i;
    assign commit_o    = loc_q & remote_eff;
    assign local_rdy_o = loc_q;
    assign done_o      = done_q;

    // Raise the ready line on a fresh request, drop it on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            loc_q  <= req_i & ~done_q & ~commit_o;
            done_q <= commit_o;
        end
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r3_ready_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !loc_q);
    a_r7_ready_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_q && !remote_eff) |=> loc_q);
    a_r3_commit_from_both: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(loc_q && remote_eff));
endmodule

// File: rtl/hsport_datapath.sv
// Data register for one bridge instance: captures pins on commit (input port)
// or holds the outgoing word from request to done (output port).
// Assumes commit_i is high only while local_rdy_i is high.
module hsport_datapath
    import hsport_pkg::*;
#(
    parameter int        DATA_W = 8,
    parameter port_dir_e DIR    = PORT_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              local_rdy_i,
    input  logic              commit_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] pin_data_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] pin_data_o
);
    logic unused_dp;
    assign unused_dp = ^{req_i, local_rdy_i, commit_i, done_i, wdata_i, pin_data_i};

    if (DIR == PORT_IN) begin : g_in
        logic [DATA_W-1:0] cap_q;

        // Capture the environment's word on the commit edge.
        always_ff @(posedge clk) begin
            if (!rst_n)        cap_q <= '0;
            else if (commit_i) cap_q <= pin_data_i;
        end

        assign rdata_o    = cap_q;
        assign pin_data_o = '0;

        a_r4_capture_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
            done_i |-> (cap_q == $past(pin_data_i)));
    end else begin : g_out
        logic [DATA_W-1:0] hold_q;
        logic              load;

        assign load = req_i & ~local_rdy_i & ~done_i;

        // Load the outgoing word as the ready line rises, then freeze it.
        always_ff @(posedge clk) begin
            if (!rst_n)    hold_q <= '0;
            else if (load) hold_q <= wdata_i;
        end

        assign pin_data_o = hold_q;
        assign rdata_o    = '0;

        a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
            (local_rdy_i && !commit_i) |=> $stable(hold_q));
    end
endmodule

// File: rtl/hsport_bridge.sv
// Top of the handshaked port bridge. Picks which pins carry the block's own
// ready line and which carry the environment's, according to DIR and the
// line-present parameters. Assumes int_req is held until int_done.
module hsport_bridge
    import hsport_pkg::*;
#(
    parameter int        DATA_W      = 8,
    parameter port_dir_e DIR         = PORT_IN,
    parameter bit        HAS_WR_LINE = 1'b1,
    parameter bit        HAS_RD_LINE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_req,
    input  logic [DATA_W-1:0] int_wdata,
    output logic [DATA_W-1:0] int_rdata,
    output logic              int_done,
    input  logic [DATA_W-1:0] ext_data_in,
    output logic [DATA_W-1:0] ext_data_out,
    input  logic              ext_wr_rdy_in,
    output logic              ext_wr_rdy_out,
    input  logic              ext_rd_rdy_in,
    output logic              ext_rd_rdy_out
);
    localparam bit IS_OUT      = (DIR == PORT_OUT);
    localparam bit REMOTE_LINE = IS_OUT ? HAS_RD_LINE : HAS_WR_LINE;
    localparam bit LOCAL_LINE  = IS_OUT ? HAS_WR_LINE : HAS_RD_LINE;

    logic remote_pin;
    logic local_rdy;
    logic commit;
    logic unused_top;

    assign remote_pin = IS_OUT ? ext_rd_rdy_in : ext_wr_rdy_in;
    assign unused_top = ^{ext_wr_rdy_in, ext_rd_rdy_in};

    hsport_sync #(.HAS_REMOTE(REMOTE_LINE)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (int_req),
        .remote_rdy_i (remote_pin),
        .local_rdy_o  (local_rdy),
        .commit_o     (commit),
        .done_o       (int_done)
    );

    hsport_datapath #(.DATA_W(DATA_W), .DIR(DIR)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (int_req),
        .local_rdy_i (local_rdy),
        .commit_i    (commit),
        .done_i      (int_done),
        .wdata_i     (int_wdata),
        .pin_data_i  (ext_data_in),
        .rdata_o     (int_rdata),
        .pin_data_o  (ext_data_out)
    );

    // Route the block's ready line to the pin for this direction.
    assign ext_wr_rdy_out = (IS_OUT && LOCAL_LINE)  ? local_rdy : 1'b0;
    assign ext_rd_rdy_out = (!IS_OUT && LOCAL_LINE) ? local_rdy : 1'b0;

    if (IS_OUT && HAS_WR_LINE && !HAS_RD_LINE) begin : g_strobe
        a_r8_valid_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            ext_wr_rdy_out |=> !ext_wr_rdy_out);
    end

    a_r10_unused_dir_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        IS_OUT ? (ext_rd_rdy_out == 1'b0) : (ext_wr_rdy_out == 1'b0 && ext_data_out == '0));
endmodule

// File: tb/sim_hsport_bridge.sv
// Scoreboard bench: five lanes, one per build variant, each instance named u0.
// Lane 0 input full, 1 output full, 2 output without receiver line,
// 3 output without lines, 4 input without sender line.
module sim_hsport_bridge;
    import hsport_pkg::*;

    localparam int W = 8;
    localparam int N = 5;

    typedef struct packed {
        logic [2:0]   k;
        logic [W-1:0] d;
    } exp_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic         req  [N];
    logic [W-1:0] wd   [N];
    logic [W-1:0] din  [N];
    logic         env  [N];
    logic         done [N];
    logic [W-1:0] rdat [N];
    logic [W-1:0] dout [N];
    logic         wro  [N];
    logic         rdo  [N];

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    for (genvar g = 0; g < N; g++) begin : lane
        hsport_bridge #(
            .DATA_W      (W),
            .DIR         ((g == 0 || g == 4) ? PORT_IN : PORT_OUT),
            .HAS_WR_LINE (g != 3 && g != 4),
            .HAS_RD_LINE (g != 2 && g != 3)
        ) u0 (
            .clk            (clk),
            .rst_n          (rst_n),
            .int_req        (req[g]),
            .int_wdata      (wd[g]),
            .int_rdata      (rdat[g]),
            .int_done       (done[g]),
            .ext_data_in    (din[g]),
            .ext_data_out   (dout[g]),
            .ext_wr_rdy_in  (env[g]),
            .ext_wr_rdy_out (wro[g]),
            .ext_rd_rdy_in  (env[g]),
            .ext_rd_rdy_out (rdo[g])
        );
    end

    function automatic bit is_out(input int k);
        return (k >= 1 && k <= 3);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
        end
    endtask

    // Monitor: pop the scoreboard on each done pulse and compare the word.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < N; k++) begin
                if (done[k]) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R3 unexpected done", k, 0);
                    end else begin
                        exp_t e;
                        logic [W-1:0] obs;
                        e = q.pop_front();
                        obs = is_out(k) ? dout[k] : rdat[k];
                        chk(e.k == 3'(k) && obs == e.d, is_out(k) ? "R5 data" : "R4 data",
                            int'(obs), int'(e.d));
                    end
                end
            end
        end
    end

    // Driver: one transfer on lane k; env ready rises after lag cycles.
    task automatic xfer(input int k, input logic [W-1:0] d, input int lag,
                        input bit hold, input int expl, input string tag);
        int   cyc;
        logic lr;
        @(negedge clk);
        req[k] = 1'b1;
        wd[k]  = d;
        din[k] = d;
        env[k] = (lag == 0);
        q.push_back('{k: 3'(k), d: d});
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            lr = is_out(k) ? wro[k] : rdo[k];
            if (done[k] || cyc > 40) break;
            chk(lr == (k != 3), (k == 3) ? "R9 ready" : ((k == 2) ? "R8 strobe" : "R2/R7 ready"),
                int'(lr), int'(k != 3));
            if (is_out(k)) begin
                chk(dout[k] == d, "R5 hold", int'(dout[k]), int'(d));
                wd[k] = ~d;
            end
            if (cyc == lag) env[k] = 1'b1;
        end
        chk(cyc == expl, tag, cyc, expl);
        chk(lr == 1'b0, "R3 ready falls", int'(lr), 0);
        req[k] = 1'b0;
        env[k] = hold;
    endtask

    task automatic quiet_checks(input string tag);
        for (int k = 0; k < N; k++) begin
            if (is_out(k)) chk(rdo[k] == 1'b0 && rdat[k] == '0, tag, int'(rdat[k]), 0);
            else           chk(wro[k] == 1'b0 && dout[k] == '0, tag, int'(dout[k]), 0);
        end
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            req[k] = 1'b0; wd[k] = '0; din[k] = '0; env[k] = 1'b0;
        end
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            chk(done[k] == 1'b0 && wro[k] == 1'b0 && rdo[k] == 1'b0, "R1 lines", int'(done[k]), 0);
            chk(dout[k] == '0 && rdat[k] == '0, "R1 data", int'(dout[k]), 0);
        end

        // Input port, full handshake.
        xfer(0, 8'hA5, 0, 1'b0, 2, "R3 latency");
        xfer(0, 8'h3C, 3, 1'b1, 4, "R7 wait");
        repeat (3) begin
            @(negedge clk);
            chk(done[0] == 1'b0 && rdo[0] == 1'b0, "R6 no request", int'(done[0]), 0);
        end
        xfer(0, 8'h81, 0, 1'b0, 2, "R6 held ready");

        // Output port, full handshake.
        xfer(1, 8'h5A, 0, 1'b0, 2, "R3 latency");
        xfer(1, 8'hF0, 4, 1'b0, 5, "R7 wait");
        xfer(1, 8'h01, 1, 1'b1, 2, "R3 latency");
        xfer(1, 8'h80, 0, 1'b0, 2, "R6 held ready");

        // Output port without receiver line: always-accept strobe.
        xfer(2, 8'h77, 0, 1'b0, 2, "R8 latency");
        xfer(2, 8'h12, 5, 1'b0, 2, "R8 latency");

        // Output port without any handshake line.
        xfer(3, 8'hC3, 0, 1'b0, 2, "R9 latency");
        @(negedge clk);
        chk(dout[3] == 8'hC3, "R9 data driven", int'(dout[3]), 8'hC3);

        // Input port without sender line.
        xfer(4, 8'h9E, 4, 1'b0, 2, "R11 latency");

        @(negedge clk);
        quiet_checks("R10 other direction");
        chk(q.size() == 0, "R3 all transfers done", q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule